// File: doc/BRIEF.md
# Tile Coverage Quad Extractor

This block stores a one-bit-per-pixel coverage mask for a 32×16 pixel screen tile and hands the covered pixels to a pixel pipeline as 2×2 quads, at most one quad per clock. An upstream scan converter fills the mask one 16-bit word per cycle. Each word covers one 4×4 pixel group, so a whole tile takes 32 write cycles. Once the mask is loaded, the pipeline raises a request. The block then finds the first quad along the space-filling path that still holds a covered pixel. It returns that quad's four pixel bits together with its block, group and quad codes, and it erases those bits so that the next request moves on.

A flag is high while any covered pixel is left in the mask. Because this flag is derived straight from the stored bits, a primitive that covers nothing in the tile shows the flag low one cycle after its last word is written, whatever the primitive's size. A synchronous clear empties the mask before the next primitive is loaded.

Top module: `tile_quad_extractor`

## Requirements
- R1: After reset the mask is empty, `more_left_o` is low and `quad_vld_o` is low.
- R2: A write stores `wr_data_i` at word address `wr_addr_i` = {Block, Group}. For pixel (x, y), Block = {y3,x4,x3} and Group = {y2,x2}. Inside the word, bit index = Quad*4 + Pos, where Quad = {y1,x1} and Pos = {y0,x0}.
- R3: `more_left_o` is high exactly when at least one mask bit is set. It reflects a write, clear or read-and-clear from the cycle after that operation.
- R4: A request accepted while bits remain gives `quad_vld_o` high on the next cycle. With it come the selected quad's four bits (bit i = Pos i) and its block, group and quad codes. The selected quad is the nonzero quad with the lowest word address, and within that word the lowest quad index.
- R5: Reading a quad clears its bits, so repeated requests visit every nonzero quad exactly once, in priority order. The mask is empty after the last one.
- R6: A request made while the mask is empty gives `quad_vld_o` low on the next cycle.
- R7: `clr_i` empties the whole mask in one cycle and takes precedence over a write or a request in the same cycle.
- R8: A request issued in the same cycle as a write is dropped. `quad_vld_o` is low on the next cycle and no quad is cleared.
- R9: Requests held on every cycle deliver one quad per cycle with no idle cycles until the mask is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Empty the whole mask |
| wr_en_i | input | 1 | Write one group word |
| wr_addr_i | input | 5 | Word address {Block, Group} |
| wr_data_i | input | 16 | Group coverage bits, Quad*4+Pos |
| get_i | input | 1 | Request the next covered quad |
| quad_o | output | 4 | Pixel bits of the returned quad |
| blk_o | output | 3 | Block code of the returned quad |
| grp_o | output | 2 | Group code of the returned quad |
| qd_o | output | 2 | Quad code of the returned quad |
| quad_vld_o | output | 1 | Returned quad is valid (one cycle after request) |
| more_left_o | output | 1 | Some mask bit is still set |

## Verification
The two functions that can collide in one cycle are the read-and-clear of a quad and a mask update, which may be a word write or a full clear. The bench issues a request in the same cycle as a write to a word, and also in the same cycle as a clear, while quads are still pending. It then judges three things: whether the valid strobe stays low, whether the written word lands intact, and whether the drain that follows matches a reference model of the mask with no quad lost or duplicated. Random masks with varied density, including empty primitives, are drained back to back against the same model.

// File: rtl/tqe_pkg.sv
package tqe_pkg;
  localparam int QUAD_PIX  = 4;                      // pixels per 2x2 quad
  localparam int QUAD_SEL  = 4;                      // quads per group word
  localparam int WORD_W    = QUAD_PIX * QUAD_SEL;    // bits per group word
  localparam int QIDX_W    = $clog2(QUAD_SEL);

  // Nonzero flag of every quad in one group word.
  function automatic logic [QUAD_SEL-1:0] quad_nz_vec(input logic [WORD_W-1:0] w);
    logic [QUAD_SEL-1:0] r;
    for (int q = 0; q < QUAD_SEL; q++) r[q] = |w[q*QUAD_PIX +: QUAD_PIX];
    return r;
  endfunction

  // Extract one quad from a group word.
  function automatic logic [QUAD_PIX-1:0] quad_of(input logic [WORD_W-1:0] w,
                                                  input logic [QIDX_W-1:0] q);
    return w[q*QUAD_PIX +: QUAD_PIX];
  endfunction
endpackage

// File: rtl/tqe_first_one.sv
module tqe_first_one #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end

  // R4: the chosen index is set and nothing below it is set.
  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << idx_o) - N'(1);
  always_comb begin
    if (any_o) begin
      a_r4_lowest_first : assert (req_i[idx_o] && ((req_i & below_mask) == '0));
    end
  end
endmodule

// File: rtl/tqe_group_sel.sv
module tqe_group_sel
  import tqe_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [QIDX_W-1:0] qidx_o,
  output logic              nz_o
);
  logic [QUAD_SEL-1:0] qnz;
  assign qnz = quad_nz_vec(word_i);

  tqe_first_one #(.N(QUAD_SEL)) i_quad_prio (
    .req_i (qnz),
    .idx_o (qidx_o),
    .any_o (nz_o)
  );
endmodule

// File: rtl/tile_quad_extractor.sv
module tile_quad_extractor
  import tqe_pkg::*;
#(
  parameter int BLK_W = 3,
  parameter int GRP_W = 2,
  localparam int ADDR_W    = BLK_W + GRP_W,
  localparam int NUM_WORDS = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic                 get_i,
  output logic [QUAD_PIX-1:0]  quad_o,
  output logic [BLK_W-1:0]     blk_o,
  output logic [GRP_W-1:0]     grp_o,
  output logic [QIDX_W-1:0]    qd_o,
  output logic                 quad_vld_o,
  output logic                 more_left_o
);
  logic [WORD_W-1:0] mask_q [NUM_WORDS];

  // Per-group priority search.
  logic [NUM_WORDS-1:0] grp_nz;
  logic [QIDX_W-1:0]    grp_qidx [NUM_WORDS];
  logic [NUM_WORDS*WORD_W-1:0] mask_flat;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_grp
    tqe_group_sel i_grp (
      .word_i (mask_q[w]),
      .qidx_o (grp_qidx[w]),
      .nz_o   (grp_nz[w])
    );
    assign mask_flat[w*WORD_W +: WORD_W] = mask_q[w];
  end

  // Global priority search across groups.
  logic [ADDR_W-1:0]   win_w;
  logic                any_left;
  tqe_first_one #(.N(NUM_WORDS)) i_glob_prio (
    .req_i (grp_nz),
    .idx_o (win_w),
    .any_o (any_left)
  );

  // Named internal events.
  logic [QIDX_W-1:0]   win_q;
  logic [QUAD_PIX-1:0] win_quad;
  logic                take;
  assign win_q    = grp_qidx[win_w];
  assign win_quad = quad_of(mask_q[win_w], win_q);
  assign take     = get_i && !wr_en_i && !clr_i && any_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) mask_q[w] <= '0;
    end else if (clr_i) begin
      for (int w = 0; w < NUM_WORDS; w++) mask_q[w] <= '0;
    end else if (wr_en_i) begin
      mask_q[wr_addr_i] <= wr_data_i;
    end else if (take) begin
      mask_q[win_w][win_q*QUAD_PIX +: QUAD_PIX] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quad_vld_o <= 1'b0;
      quad_o     <= '0;
      blk_o      <= '0;
      grp_o      <= '0;
      qd_o       <= '0;
    end else begin
      quad_vld_o <= take;
      if (take) begin
        quad_o <= win_quad;
        blk_o  <= win_w[ADDR_W-1:GRP_W];
        grp_o  <= win_w[GRP_W-1:0];
        qd_o   <= win_q;
      end
    end
  end

  assign more_left_o = any_left;

  // Assertions
  a_r4_vld_after_req : assert property (@(posedge clk) disable iff (!rst_n)
    quad_vld_o |-> $past(get_i));
  a_r4_vld_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
    quad_vld_o |-> (quad_o != '0));
  a_r5_bits_removed : assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(mask_flat) == $past($countones(mask_flat)) - $countones($past(win_quad))));
  a_r7_clear_empties : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !more_left_o);
  a_r8_write_blocks_req : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i || clr_i) |=> !quad_vld_o);
  a_r3_flag_matches_mask : assert property (@(posedge clk) disable iff (!rst_n)
    more_left_o == (mask_flat != '0));
endmodule

// File: tb/test_tile_quad_extractor.sv
module test_tile_quad_extractor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i, wr_en_i, get_i;
  logic [4:0]  wr_addr_i;
  logic [15:0] wr_data_i;
  logic [3:0]  quad_o;
  logic [2:0]  blk_o;
  logic [1:0]  grp_o, qd_o;
  logic        quad_vld_o, more_left_o;

  always #5 clk = ~clk;

  tile_quad_extractor i_tile_quad_extractor (
    .clk, .rst_n, .clr_i, .wr_en_i, .wr_addr_i, .wr_data_i, .get_i,
    .quad_o, .blk_o, .grp_o, .qd_o, .quad_vld_o, .more_left_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mdl [32];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pixel (x,y) -> word address and bit index, per R2.
  function automatic logic [4:0] addr_of(input logic [4:0] x, input logic [3:0] y);
    return {y[3], x[4], x[3], y[2], x[2]};
  endfunction
  function automatic logic [3:0] bit_of(input logic [4:0] x, input logic [3:0] y);
    return {y[1], x[1], y[0], x[0]};
  endfunction

  function automatic bit mdl_any();
    for (int w = 0; w < 32; w++) if (mdl[w] != 0) return 1;
    return 0;
  endfunction

  // One clock: drive at a falling edge, check at the next.
  task automatic cyc(input bit c, input bit w, input logic [4:0] a,
                     input logic [15:0] d, input bit g, input string tag);
    bit exp_take = 0;
    int ew = 0, eq = 0;
    logic [3:0] equad = 0;
    if (g && !w && !c) begin
      for (int wi = 0; wi < 32 && !exp_take; wi++)
        for (int qi = 0; qi < 4 && !exp_take; qi++)
          if (mdl[wi][qi*4 +: 4] != 0) begin
            exp_take = 1; ew = wi; eq = qi; equad = mdl[wi][qi*4 +: 4];
          end
    end
    clr_i = c; wr_en_i = w; wr_addr_i = a; wr_data_i = d; get_i = g;
    if (c) for (int wi = 0; wi < 32; wi++) mdl[wi] = 0;
    else if (w) mdl[a] = d;
    else if (exp_take) mdl[ew][eq*4 +: 4] = 0;
    @(negedge clk);
    clr_i = 0; wr_en_i = 0; get_i = 0;
    if (g) chk(quad_vld_o == exp_take, {tag, " vld"}, quad_vld_o, exp_take);
    if (exp_take) begin
      chk(quad_o == equad, {tag, " quad bits"}, quad_o, equad);
      chk({blk_o, grp_o} == 5'(ew), {tag, " block/group"}, {blk_o, grp_o}, ew);
      chk(qd_o == 2'(eq), {tag, " quad code"}, qd_o, eq);
    end
    chk(more_left_o == mdl_any(), "R3 more_left", more_left_o, mdl_any());
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (mdl_any() && guard < 200) begin
      cyc(0, 0, 0, 0, 1, tag);   // R9: back-to-back requests
      guard++;
    end
    chk(guard <= 128, "R9 drain length", guard, 128);
    cyc(0, 0, 0, 0, 1, "R6 empty request");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    for (int wi = 0; wi < 32; wi++) mdl[wi] = 0;
    rst_n = 0; clr_i = 0; wr_en_i = 0; get_i = 0; wr_addr_i = 0; wr_data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(more_left_o == 0, "R1 more_left after reset", more_left_o, 0);
    chk(quad_vld_o == 0, "R1 vld after reset", quad_vld_o, 0);
    cyc(0, 0, 0, 0, 1, "R6 request on empty");

    // Directed pixel (5,9): block 4, group 1, quad 0, pos 3.
    cyc(0, 1, addr_of(5'd5, 4'd9), 16'(1) << bit_of(5'd5, 4'd9), 0, "R2 write");
    chk(addr_of(5'd5, 4'd9) == 5'd17, "R2 address map", addr_of(5'd5, 4'd9), 17);
    cyc(0, 0, 0, 0, 1, "R4 single pixel");
    chk(quad_o == 4'b1000 && blk_o == 3'd4 && grp_o == 2'd1 && qd_o == 2'd0,
        "R2 R4 directed codes", {quad_o, blk_o, grp_o, qd_o}, {4'b1000, 3'd4, 2'd1, 2'd0});
    chk(more_left_o == 0, "R5 empty after last quad", more_left_o, 0);

    // Priority order within a word and across words.
    cyc(0, 1, 5'd3, 16'h0F00, 0, "R2 write");
    cyc(0, 1, 5'd2, 16'h8001, 0, "R2 write");
    drain("R4 R5 priority order");

    // Empty primitive: 32 zero words.
    for (int wi = 0; wi < 32; wi++) cyc(0, 1, 5'(wi), 16'h0, 0, "R3 empty primitive");
    chk(more_left_o == 0, "R3 empty flag after load", more_left_o, 0);

    // Random primitives.
    for (int p = 0; p < 8; p++) begin
      cyc(1, 0, 0, 0, 0, "R7 clear");
      for (int wi = 0; wi < 32; wi++) begin
        logic [15:0] d;
        d = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom & $urandom);
        if (p == 3) d = 16'hFFFF;
        cyc(0, 1, 5'(wi), d, 0, "R2 load");
      end
      for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 1, "R4 R9 random");
      cyc(0, 1, 5'($urandom % 32), 16'($urandom), 1, "R8 write with request");
      for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 1, "R4 after collision");
      if (p == 5) begin
        cyc(1, 1, 5'd0, 16'hFFFF, 1, "R7 clear beats write and request");
        chk(more_left_o == 0, "R7 clear precedence", more_left_o, 0);
      end
      drain("R5 random drain");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule